// File: doc/BRIEF.md
# Burst Stream-to-Memory Writer

The block moves packet data from a ready/valid stream into memory. Each command names a start address, a length in bytes and whether the address advances. For every command the block accepts stream beats into a small internal buffer and writes them out through a burst-capable memory-mapped write master. A full-length burst is started only once the buffer already holds every beat of it, so a burst never stalls in the middle for lack of data. Only the last burst of a command may be shorter, and it carries the leftover beats.

A stream beat flagged as end-of-packet ends the command's data at once, even when the requested length has not been reached. In that case the last burst holds only the beats received. When the last beat has been written, the block raises a one-cycle status token with the number of bytes actually written and a flag telling whether an end-of-packet closed the transfer. After that it is ready for the next command. It fits behind a command queue in stream-to-memory paths, and behind a read engine's data queue in memory-to-memory copies.

Top module: `stream_burst_writer`

## Requirements
- R1: Out of reset, and whenever no command is active, `cmd_ready` is 1, `m_write` is 0 and `snk_ready` is 0. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 until that command's status token.
- R2: Every accepted stream beat is written to memory exactly once. Writes come in acceptance order and carry the beat's data unchanged.
- R3: `cmd_len` is a byte count and must be a multiple of DATA_W/8. The command takes `cmd_len`/(DATA_W/8) beats. A zero length produces no write and a status token of 0 bytes.
- R4: `m_burstcount` is BURST_BEATS on every burst of a command except the last. The last burst carries the remaining 1..BURST_BEATS beats. The value is the same on every beat of a burst.
- R5: A burst of BURST_BEATS beats starts only when at least that many beats of the command are buffered and not yet written. A shorter final burst starts only after every beat of the command has been accepted from the stream.
- R6: The buffer holds 2×BURST_BEATS beats. Accepted-but-unwritten beats never exceed that count, and `snk_ready` is 0 while the buffer is full.
- R7: The first write beat of a command goes to `cmd_addr`. Each following beat's address is DATA_W/8 higher when `cmd_incr` is 1, and is unchanged when it is 0.
- R8: A beat with `snk_eop` = 1 is the last beat taken for the command, even before the length is reached. `sts_bytes` equals the beats taken times DATA_W/8. `sts_eop` is 1 exactly when the last beat taken carried end-of-packet.
- R9: `sts_valid` is a single-cycle pulse that comes after the command's last write beat has been accepted. In the same cycle `cmd_ready` is 1.
- R10: While `m_write` = 1 and `m_waitrequest` = 1, `m_write`, `m_addr`, `m_wdata` and `m_burstcount` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Transfer length in bytes |
| cmd_incr | input | 1 | Advance the address after each beat |
| snk_valid | input | 1 | Stream beat offered |
| snk_ready | output | 1 | Stream beat can be taken |
| snk_data | input | DATA_W | Stream beat data |
| snk_eop | input | 1 | Beat closes the packet |
| m_write | output | 1 | Write beat presented |
| m_addr | output | ADDR_W | Byte address of the write beat |
| m_wdata | output | DATA_W | Write data |
| m_burstcount | output | $clog2(BURST_BEATS+1) | Beats in the current burst |
| m_waitrequest | input | 1 | Memory stalls the presented beat |
| sts_valid | output | 1 | Status token pulse |
| sts_bytes | output | LEN_W | Bytes actually written |
| sts_eop | output | 1 | Transfer closed by end-of-packet |

## Verification
The condition hardest to reach from the ports is a full buffer. The memory side must stall a burst for long enough that the stream fills all 2×BURST_BEATS entries and `snk_ready` drops. The bench gets there by holding `m_waitrequest` high for a fixed stretch while the stream offers a long command on every cycle. It then checks the exact occupancy and the blocked sink before releasing the stall. Short final bursts are reached through lengths that are not a multiple of the burst size, and through end-of-packet beats placed before, at and well ahead of the length. Random stream gaps and memory stalls then move where each burst begins.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  // Write engine phases: waiting for enough buffered data, or presenting a burst.
  typedef enum logic [0:0] {
    WR_IDLE  = 1'b0,
    WR_BURST = 1'b1
  } wr_state_e;

endpackage

// File: rtl/sbw_fifo.sv
module sbw_fifo #(
  parameter  int W     = 32,
  parameter  int DEPTH = 8,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign count   = cnt_q;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (do_push) wp_n = ptr_inc(wp_q);
    if (do_pop)  rp_n = ptr_inc(rp_q);
    if (do_push && !do_pop)      cnt_n = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // Storage carries no reset; only the pointers qualify its contents.
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

endmodule

// File: rtl/sbw_ingest.sv
module sbw_ingest #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] start_beats,
  input  logic             active,
  input  logic             space_ok,
  input  logic             snk_valid,
  input  logic             snk_eop,
  output logic             snk_ready,
  output logic             take,
  output logic             in_done,
  output logic [LEN_W-1:0] taken,
  output logic             eop_seen
);

  logic [LEN_W-1:0] left_q, left_n;
  logic [LEN_W-1:0] taken_q, taken_n;
  logic             done_q, done_n;
  logic             eop_q, eop_n;

  assign snk_ready = active && !done_q && space_ok;
  assign take      = snk_valid && snk_ready;
  assign in_done   = done_q;
  assign taken     = taken_q;
  assign eop_seen  = eop_q;

  always_comb begin
    left_n  = left_q;
    taken_n = taken_q;
    done_n  = done_q;
    eop_n   = eop_q;
    if (start) begin
      left_n  = start_beats;
      taken_n = '0;
      done_n  = (start_beats == '0);
      eop_n   = 1'b0;
    end else if (take) begin
      left_n  = left_q - LEN_W'(1);
      taken_n = taken_q + LEN_W'(1);
      eop_n   = snk_eop;
      if (snk_eop || (left_q == LEN_W'(1))) done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      taken_q <= '0;
      done_q  <= 1'b0;
      eop_q   <= 1'b0;
    end else begin
      left_q  <= left_n;
      taken_q <= taken_n;
      done_q  <= done_n;
      eop_q   <= eop_n;
    end
  end

endmodule

// File: rtl/sbw_wengine.sv
module sbw_wengine
  import sbw_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  parameter  int BURST  = 4,
  parameter  int CW     = 4,
  localparam int BC_W   = $clog2(BURST + 1),
  localparam int BPB    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_incr,
  input  logic              active,
  input  logic              in_done,
  input  logic [CW-1:0]     fifo_cnt,
  input  logic [DATA_W-1:0] fifo_dout,
  output logic              fifo_pop,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  output logic [BC_W-1:0]   m_burstcount,
  input  logic              m_waitrequest,
  output logic              eng_idle
);

  wr_state_e         st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              incr_q, incr_n;
  logic [BC_W-1:0]   blen_q, blen_n;
  logic [BC_W-1:0]   bleft_q, bleft_n;
  logic              full_ready, tail_ready;
  logic [BC_W-1:0]   pick_len;

  // A full burst needs BURST beats on hand; a tail burst needs the command's input closed.
  assign full_ready = (fifo_cnt >= CW'(BURST));
  assign tail_ready = in_done && (fifo_cnt != '0);
  assign pick_len   = full_ready ? BC_W'(BURST) : BC_W'(fifo_cnt);

  always_comb begin
    st_n     = st_q;
    addr_n   = addr_q;
    incr_n   = incr_q;
    blen_n   = blen_q;
    bleft_n  = bleft_q;
    fifo_pop = 1'b0;
    if (start) begin
      addr_n = start_addr;
      incr_n = start_incr;
    end
    unique case (st_q)
      WR_IDLE: begin
        if (active && (full_ready || tail_ready)) begin
          st_n    = WR_BURST;
          blen_n  = pick_len;
          bleft_n = pick_len;
        end
      end
      WR_BURST: begin
        if (!m_waitrequest) begin
          fifo_pop = 1'b1;
          bleft_n  = bleft_q - BC_W'(1);
          if (incr_q) addr_n = addr_q + ADDR_W'(BPB);
          if (bleft_q == BC_W'(1)) st_n = WR_IDLE;
        end
      end
      default: st_n = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WR_IDLE;
      addr_q  <= '0;
      incr_q  <= 1'b0;
      blen_q  <= '0;
      bleft_q <= '0;
    end else begin
      st_q    <= st_n;
      addr_q  <= addr_n;
      incr_q  <= incr_n;
      blen_q  <= blen_n;
      bleft_q <= bleft_n;
    end
  end

  assign m_write      = (st_q == WR_BURST);
  assign m_addr       = addr_q;
  assign m_wdata      = fifo_dout;
  assign m_burstcount = blen_q;
  assign eng_idle     = (st_q == WR_IDLE);

endmodule

// File: rtl/stream_burst_writer.sv
module stream_burst_writer #(
  parameter  int ADDR_W      = 32,
  parameter  int DATA_W      = 32,
  parameter  int LEN_W       = 16,
  parameter  int BURST_BEATS = 4,
  localparam int BPB         = DATA_W / 8,
  localparam int BSH         = (BPB > 1) ? $clog2(BPB) : 0,
  localparam int DEPTH       = 2 * BURST_BEATS,
  localparam int CW          = $clog2(DEPTH + 1),
  localparam int BC_W        = $clog2(BURST_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_incr,
  input  logic              snk_valid,
  output logic              snk_ready,
  input  logic [DATA_W-1:0] snk_data,
  input  logic              snk_eop,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  output logic [BC_W-1:0]   m_burstcount,
  input  logic              m_waitrequest,
  output logic              sts_valid,
  output logic [LEN_W-1:0]  sts_bytes,
  output logic              sts_eop
);

  logic             busy_q, busy_n;
  logic             stv_q, stv_n;
  logic [LEN_W-1:0] stb_q, stb_n;
  logic             ste_q, ste_n;

  logic             start;
  logic [LEN_W-1:0] beats;
  logic             take, in_done, eop_seen;
  logic [LEN_W-1:0] taken;
  logic             fifo_pop, fifo_full, fifo_empty;
  logic [CW-1:0]    fifo_cnt;
  logic [DATA_W-1:0] fifo_dout;
  logic             eng_idle;
  logic             finish;

  assign cmd_ready = !busy_q;
  assign start     = cmd_valid && !busy_q;
  assign beats     = cmd_len >> BSH;
  assign finish    = busy_q && in_done && eng_idle && fifo_empty;

  sbw_ingest #(.LEN_W(LEN_W)) u_ingest (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_beats (beats),
    .active      (busy_q),
    .space_ok    (!fifo_full),
    .snk_valid   (snk_valid),
    .snk_eop     (snk_eop),
    .snk_ready   (snk_ready),
    .take        (take),
    .in_done     (in_done),
    .taken       (taken),
    .eop_seen    (eop_seen)
  );

  sbw_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (take),
    .din   (snk_data),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  sbw_wengine #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BURST  (BURST_BEATS),
    .CW     (CW)
  ) u_weng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_addr    (cmd_addr),
    .start_incr    (cmd_incr),
    .active        (busy_q),
    .in_done       (in_done),
    .fifo_cnt      (fifo_cnt),
    .fifo_dout     (fifo_dout),
    .fifo_pop      (fifo_pop),
    .m_write       (m_write),
    .m_addr        (m_addr),
    .m_wdata       (m_wdata),
    .m_burstcount  (m_burstcount),
    .m_waitrequest (m_waitrequest),
    .eng_idle      (eng_idle)
  );

  always_comb begin
    busy_n = busy_q;
    stv_n  = finish;
    stb_n  = stb_q;
    ste_n  = ste_q;
    if (start)       busy_n = 1'b1;
    else if (finish) busy_n = 1'b0;
    if (finish) begin
      stb_n = taken << BSH;
      ste_n = eop_seen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      stv_q  <= 1'b0;
      stb_q  <= '0;
      ste_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      stv_q  <= stv_n;
      stb_q  <= stb_n;
      ste_q  <= ste_n;
    end
  end

  assign sts_valid = stv_q;
  assign sts_bytes = stb_q;
  assign sts_eop   = ste_q;

endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BURST_BEATS = 4,
  parameter int BC_W        = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              snk_ready,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic [BC_W-1:0]   m_burstcount,
  input logic              m_waitrequest,
  input logic              sts_valid
);

  // R10: a stalled beat is held unchanged
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && m_waitrequest) |=> (m_write && $stable(m_addr) && $stable(m_wdata)
                                    && $stable(m_burstcount)));

  // R4: burst length within 1..BURST_BEATS
  a_r4_burst_range: assert property (@(posedge clk) disable iff (!rst_n)
    m_write |-> ((m_burstcount != '0) && (m_burstcount <= BC_W'(BURST_BEATS))));

  // R1: idle block neither writes nor takes stream data
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!m_write && !snk_ready));

  // R9: status is a single-cycle pulse
  a_r9_status_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |=> !sts_valid);

  // R9: status coincides with readiness for the next command
  a_r9_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> cmd_ready);

endmodule

bind stream_burst_writer sbw_checker #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .BURST_BEATS (BURST_BEATS),
  .BC_W        (BC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .snk_ready     (snk_ready),
  .m_write       (m_write),
  .m_addr        (m_addr),
  .m_wdata       (m_wdata),
  .m_burstcount  (m_burstcount),
  .m_waitrequest (m_waitrequest),
  .sts_valid     (sts_valid)
);

// File: tb/stream_burst_writer_tb.sv
`timescale 1ns/1ps
module stream_burst_writer_tb;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 16;
  localparam int BURST  = 4;
  localparam int BPB    = 4;
  localparam int BC_W   = 3;
  localparam int DEPTH  = 2 * BURST;

  logic              clk, rst_n;
  logic              cmd_valid, cmd_ready, cmd_incr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic              snk_valid, snk_ready, snk_eop;
  logic [DATA_W-1:0] snk_data;
  logic              m_write, m_waitrequest;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata;
  logic [BC_W-1:0]   m_burstcount;
  logic              sts_valid, sts_eop;
  logic [LEN_W-1:0]  sts_bytes;

  stream_burst_writer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .BURST_BEATS(BURST)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_incr(cmd_incr),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data), .snk_eop(snk_eop),
    .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_burstcount(m_burstcount), .m_waitrequest(m_waitrequest),
    .sts_valid(sts_valid), .sts_bytes(sts_bytes), .sts_eop(sts_eop)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { logic [ADDR_W-1:0] addr; logic [LEN_W-1:0] len; bit incr; int n; } cmd_t;
  typedef struct { logic [ADDR_W-1:0] addr; logic [DATA_W-1:0] data; int bc; } wr_t;
  typedef struct { int bytes; bit eop; } st_t;
  typedef struct { logic [DATA_W-1:0] data; bit eop; } beat_t;

  cmd_t  cmd_q[$];
  beat_t beat_q[$];
  wr_t   wr_q[$];
  st_t   st_q[$];

  int n_cmp = 0, n_bad = 0;
  int valid_pct = 100, wait_pct = 0;
  int acc_cmd = 0, wr_cmd = 0, cur_n = 0, bleft_b = 0;
  int cyc = 0, sts_got = 0, n_cmds = 0;
  bit timeout = 0, busy_b = 0, prev_hold = 0;
  logic [ADDR_W-1:0] prev_addr;
  logic [DATA_W-1:0] prev_data;
  logic [BC_W-1:0]   prev_bc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: beats taken, burst split, addresses, status.
  task automatic add_cmd(input logic [ADDR_W-1:0] addr, input int beats,
                         input bit incr, input int eop_at);
    cmd_t c;
    int n, full;
    bit eflag;
    eflag  = (eop_at > 0) && (eop_at <= beats);
    n      = eflag ? eop_at : beats;
    full   = (n / BURST) * BURST;
    c.addr = addr; c.len = LEN_W'(beats * BPB); c.incr = incr; c.n = n;
    cmd_q.push_back(c);
    for (int i = 0; i < n; i++) begin
      beat_t b;
      wr_t   w;
      b.data = $urandom;
      b.eop  = eflag && (i == n - 1);
      beat_q.push_back(b);
      w.data = b.data;
      w.addr = incr ? addr + ADDR_W'(i * BPB) : addr;
      w.bc   = (i < full) ? BURST : (n - full);
      wr_q.push_back(w);
    end
    st_q.push_back('{bytes: n * BPB, eop: eflag});
    n_cmds++;
  endtask

  task automatic wait_all();
    while ((sts_got < n_cmds) && !timeout) @(posedge clk);
  endtask

  // Drive at the falling edge, observe 5 ns later, before the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_q.size() > 0) begin
        cmd_valid = 1'b1;
        cmd_addr  = cmd_q[0].addr;
        cmd_len   = cmd_q[0].len;
        cmd_incr  = cmd_q[0].incr;
      end else begin
        cmd_valid = 1'b0;
      end
      if (rst_n && beat_q.size() > 0 && (($urandom % 100) < valid_pct)) begin
        snk_valid = 1'b1;
        snk_data  = beat_q[0].data;
        snk_eop   = beat_q[0].eop;
      end else begin
        snk_valid = 1'b0;
        snk_eop   = 1'b0;
      end
      m_waitrequest = (($urandom % 100) < wait_pct);
      #5;
      cyc++;
      if (cyc > 150000 && !timeout) begin
        timeout = 1;
        chk(0, "WD", "watchdog expired", cyc, 0);
      end
      if (rst_n) begin
        if (prev_hold)
          chk(m_write && m_addr == prev_addr && m_wdata == prev_data && m_burstcount == prev_bc,
              "R10", "beat held under stall", m_addr, prev_addr);
        prev_hold = m_write && m_waitrequest;
        prev_addr = m_addr; prev_data = m_wdata; prev_bc = m_burstcount;

        if (m_write && bleft_b == 0) begin
          bleft_b = int'(m_burstcount);
          if (m_burstcount == BC_W'(BURST))
            chk(acc_cmd - wr_cmd >= BURST, "R5", "full burst buffered", acc_cmd - wr_cmd, BURST);
          else
            chk(acc_cmd == cur_n, "R5", "short burst after all input", acc_cmd, cur_n);
        end

        if (m_write && !m_waitrequest) begin
          if (wr_q.size() == 0) chk(0, "R2", "unexpected write", m_addr, 0);
          else begin
            wr_t e;
            e = wr_q.pop_front();
            chk(m_wdata == e.data, "R2", "write data", m_wdata, e.data);
            chk(m_addr == e.addr, "R7", "write address", m_addr, e.addr);
            chk(int'(m_burstcount) == e.bc, "R4", "burst count", m_burstcount, e.bc);
          end
          wr_cmd++;
          bleft_b--;
        end

        if (sts_valid) begin
          if (st_q.size() == 0) chk(0, "R9", "unexpected status", sts_bytes, 0);
          else begin
            st_t s;
            s = st_q.pop_front();
            chk(int'(sts_bytes) == s.bytes, "R8", "status bytes (R3 length)", sts_bytes, s.bytes);
            chk(sts_eop == s.eop, "R8", "status eop flag", sts_eop, s.eop);
          end
          chk(wr_cmd == cur_n, "R9", "all writes before status", wr_cmd, cur_n);
          sts_got++;
          busy_b = 0;
        end

        chk(cmd_ready == !busy_b, "R1", "cmd_ready tracks activity", cmd_ready, !busy_b);
        chk(acc_cmd - wr_cmd <= DEPTH, "R6", "buffer bound", acc_cmd - wr_cmd, DEPTH);

        if (cmd_valid && cmd_ready) begin
          cmd_t c;
          c = cmd_q.pop_front();
          cur_n = c.n; acc_cmd = 0; wr_cmd = 0; busy_b = 1;
        end
        if (snk_valid && snk_ready) begin
          void'(beat_q.pop_front());
          acc_cmd++;
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0; cmd_incr = 1'b0;
    snk_valid = 1'b0; snk_data = '0; snk_eop = 1'b0; m_waitrequest = 1'b0;
    repeat (3) @(negedge clk);
    #7;
    chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
    chk(m_write == 1'b0, "R1", "reset m_write", m_write, 0);
    chk(snk_ready == 1'b0, "R1", "reset snk_ready", snk_ready, 0);
    chk(sts_valid == 1'b0, "R9", "reset sts_valid", sts_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: exact burst, R4 split 4/4/2, fixed address R7, zero length R3, early eop R8
    add_cmd(32'h0000_1000, 4, 1, 0);
    add_cmd(32'h0000_2000, 10, 1, 0);
    add_cmd(32'h0000_3000, 3, 0, 0);
    add_cmd(32'h0000_4000, 0, 1, 0);
    add_cmd(32'h0000_5000, 8, 1, 5);
    add_cmd(32'h0000_6000, 6, 1, 6);
    add_cmd(32'h0000_7000, 4, 1, 1);
    wait_all();

    // Random gaps and stalls
    valid_pct = 60; wait_pct = 40;
    for (int k = 0; k < 14; k++) begin
      int bt, ep;
      bt = $urandom % 14;
      ep = (bt > 0 && ($urandom % 100) < 35) ? 1 + ($urandom % bt) : 0;
      add_cmd(ADDR_W'(32'h0001_0000 + k * 32'h100), bt, bit'($urandom % 2), ep);
    end
    wait_all();

    // R6: stall memory until the buffer is full
    valid_pct = 100; wait_pct = 100;
    add_cmd(32'h0000_9000, 20, 1, 0);
    repeat (40) @(negedge clk);
    #7;
    chk(acc_cmd - wr_cmd == DEPTH, "R6", "buffer filled to depth", acc_cmd - wr_cmd, DEPTH);
    chk(snk_ready == 1'b0, "R6", "sink blocked when full", snk_ready, 0);
    wait_pct = 25;
    wait_all();

    repeat (5) @(negedge clk);
    #7;
    chk(wr_q.size() == 0, "R2", "no writes left over", wr_q.size(), 0);
    chk(st_q.size() == 0, "R9", "no status left over", st_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule